// File: doc/BRIEF.md
# Converter Master Serial Readout Controller

This block is the digital output side of a sampling converter that drives its own serial port. A one-cycle start strobe begins a conversion that lasts a fixed number of system clocks. At the end of the conversion the sample word on `sample_i` is stored as the result. When the clock-source select input is low, the block acts as the serial master. It generates a serial clock, a framing strobe that marks valid data and a data line, and it drives a busy flag.

Two read orders are available. With `rd_mode_i` low, the word that was just converted is sent as soon as its conversion ends, and busy stays high until the last bit has gone out. With `rd_mode_i` high, the stored word from the previous conversion is sent while the new conversion runs, and busy falls when the conversion ends. Separate polarity inputs invert the serial clock and the strobe. The serial pins move only while both active-low select inputs are low.

The parameters must satisfy `CONV_CYCLES >= 16 * SCK_DIV`, and `SCK_DIV` must be even and at least 2. These conditions let a read-during-conversion transfer finish by the end of the conversion. With the defaults, `CONV_CYCLES = 32` and `SCK_DIV = 2`.

Top module: `conv_serial_master`

## Requirements
- R1: While reset is held, `busy_o` is 0 and `sdo_o` is 0. `sck_o` equals `inv_sck_i` and `sync_o` equals `inv_sync_i`, which are the idle levels.
- R2: A start strobe sampled while `busy_o` is low raises `busy_o` on the next cycle. The conversion then lasts `CONV_CYCLES` cycles, and on its last cycle the value of `sample_i` is stored as the result.
- R3: With `rd_mode_i` = 0, the transfer of the word just captured begins on the cycle after the conversion ends. `busy_o` stays high through all 16 bit periods, which is 64 cycles after the start with the defaults.
- R4: With `rd_mode_i` = 1, the transfer of the previously stored result begins on the cycle after the start is accepted, and `busy_o` falls after `CONV_CYCLES` cycles. Before any conversion has finished, the stored result is 0x0000.
- R5: The 16 bits go out most significant bit first, one bit every `SCK_DIV` cycles. The non-inverted clock is low in the first half of each bit period and high in the second half. The data line changes only while that clock is low.
- R6: The strobe is active for exactly 16 × `SCK_DIV` cycles, which covers every bit period of the transfer.
- R7: When `inv_sck_i` = 1 the clock output is inverted, so it idles high. When `inv_sync_i` = 1 the strobe output is inverted, so it is active low.
- R8: A start strobe that arrives while `busy_o` is high is ignored: the conversion length and the busy length do not change.
- R9: The serial outputs move only when `cs_n_i` = 0 and `rd_n_i` = 0. Otherwise `sdo_o` is 0, `sck_o` sits at its idle level and `sync_o` is inactive, and the conversion and busy timing are unchanged.
- R10: With `ext_clk_sel_i` = 1, no transfer is made and `busy_o` falls at the end of the conversion in either mode. The result is still stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion start strobe |
| ext_clk_sel_i | input | 1 | 0 = block drives the serial clock, 1 = no master transfer |
| rd_mode_i | input | 1 | 0 = read after conversion, 1 = read previous word during conversion |
| inv_sck_i | input | 1 | Invert the serial clock output |
| inv_sync_i | input | 1 | Invert the strobe output |
| cs_n_i | input | 1 | Active-low select |
| rd_n_i | input | 1 | Active-low read enable |
| sample_i | input | 16 | Word captured at the end of a conversion |
| busy_o | output | 1 | Conversion or read-after transfer in progress |
| sck_o | output | 1 | Serial clock |
| sync_o | output | 1 | Data-valid strobe |
| sdo_o | output | 1 | Serial data, MSB first |

## Verification
In read-during-conversion mode, three things happen on the same clock edge: the last bit period of the outgoing transfer ends, the conversion ends, and the new result is stored. The bench provokes this by running back-to-back read-during conversions with different sample words. It judges the edge by checking that each transfer carries the word from the previous conversion with its least significant bit intact, and that busy falls after exactly 32 cycles. In read-after mode, the capture and the transfer launch share one cycle. A following read-during transfer must return the word that the read-after run captured.

// File: rtl/conv_pkg.sv
package conv_pkg;
  localparam int unsigned WORD_W = 16;

  typedef enum logic {
    ORD_AFTER  = 1'b0,
    ORD_DURING = 1'b1
  } read_order_e;
endpackage

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int unsigned CONV_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  output logic run_o,
  output logic done_o
);
  localparam int unsigned CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last_w;

  assign last_w = run_q && (cnt_q == LAST);

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (go_i && !run_q) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (last_w) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (run_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign run_o  = run_q;
  assign done_o = last_w;

  // R8: once running, the count advances and is never restarted mid-conversion
  a_r8_steady_count: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !last_w) |=> (run_q && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/serial_shifter.sv
module serial_shifter #(
  parameter int unsigned W       = 16,
  parameter int unsigned SCK_DIV = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         launch_i,
  input  logic [W-1:0] word_i,
  output logic         active_o,
  output logic         done_o,
  output logic         sdo_raw_o,
  output logic         sck_raw_o
);
  localparam int unsigned HALF = SCK_DIV / 2;
  localparam int unsigned PW   = (SCK_DIV > 1) ? $clog2(SCK_DIV) : 1;
  localparam int unsigned BW   = (W > 1) ? $clog2(W) : 1;
  localparam logic [PW-1:0] PH_LAST  = PW'(SCK_DIV - 1);
  localparam logic [PW-1:0] PH_HIGH  = PW'(HALF);
  localparam logic [BW-1:0] BIT_LAST = BW'(W - 1);

  logic          act_q, act_d;
  logic [PW-1:0] ph_q, ph_d;
  logic [BW-1:0] bc_q, bc_d;
  logic [W-1:0]  sr_q, sr_d;
  logic          period_end;

  assign period_end = act_q && (ph_q == PH_LAST);

  always_comb begin
    act_d = act_q;
    ph_d  = ph_q;
    bc_d  = bc_q;
    sr_d  = sr_q;
    if (launch_i && !act_q) begin
      act_d = 1'b1;
      ph_d  = '0;
      bc_d  = '0;
      sr_d  = word_i;
    end else if (period_end) begin
      ph_d = '0;
      sr_d = {sr_q[W-2:0], 1'b0};
      if (bc_q == BIT_LAST) begin
        act_d = 1'b0;
        bc_d  = '0;
      end else begin
        bc_d = bc_q + 1'b1;
      end
    end else if (act_q) begin
      ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= '0;
      bc_q  <= '0;
      sr_q  <= '0;
    end else begin
      act_q <= act_d;
      ph_q  <= ph_d;
      bc_q  <= bc_d;
      sr_q  <= sr_d;
    end
  end

  assign active_o  = act_q;
  assign done_o    = period_end && (bc_q == BIT_LAST);
  assign sdo_raw_o = act_q && sr_q[W-1];
  assign sck_raw_o = act_q && (ph_q >= PH_HIGH);

  // R5: the data line moves only while the non-inverted clock is low
  a_r5_data_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q) && (sdo_raw_o != $past(sdo_raw_o))) |-> !sck_raw_o);

  // R6: a transfer ends only after the final bit period
  a_r6_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> ($past(bc_q) == BIT_LAST));
endmodule

// File: rtl/conv_serial_master.sv
module conv_serial_master
  import conv_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 32,
  parameter int unsigned SCK_DIV     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              ext_clk_sel_i,
  input  logic              rd_mode_i,
  input  logic              inv_sck_i,
  input  logic              inv_sync_i,
  input  logic              cs_n_i,
  input  logic              rd_n_i,
  input  logic [WORD_W-1:0] sample_i,
  output logic              busy_o,
  output logic              sck_o,
  output logic              sync_o,
  output logic              sdo_o
);
  // reset: asynchronous assertion, synchronous release
  logic rst_s1_q, rst_s2_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  read_order_e       ord_q, ord_d;
  logic              ext_q, ext_d;
  logic              busy_q, busy_d;
  logic [WORD_W-1:0] result_q, result_d;
  logic              accept, conv_run, conv_done;
  logic              launch_during, launch_after, launch;
  logic [WORD_W-1:0] launch_word;
  logic              sh_active, sh_done, sdo_raw, sck_raw;
  logic              out_en;

  assign accept        = start_i && !busy_q;
  assign launch_during = accept && rd_mode_i && !ext_clk_sel_i;
  assign launch_after  = conv_done && (ord_q == ORD_AFTER) && !ext_q;
  assign launch        = launch_during || launch_after;
  assign launch_word   = launch_after ? sample_i : result_q;

  always_comb begin
    ord_d    = ord_q;
    ext_d    = ext_q;
    busy_d   = busy_q;
    result_d = result_q;
    if (accept) begin
      busy_d = 1'b1;
      ord_d  = read_order_e'(rd_mode_i);
      ext_d  = ext_clk_sel_i;
    end
    if (conv_done) begin
      result_d = sample_i;
      if (ord_q == ORD_DURING || ext_q) busy_d = 1'b0;
    end
    if (sh_done && ord_q == ORD_AFTER && busy_q) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ord_q    <= ORD_AFTER;
      ext_q    <= 1'b0;
      busy_q   <= 1'b0;
      result_q <= '0;
    end else begin
      ord_q    <= ord_d;
      ext_q    <= ext_d;
      busy_q   <= busy_d;
      result_q <= result_d;
    end
  end

  conv_timer #(.CONV_CYCLES(CONV_CYCLES)) timer_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .go_i   (accept),
    .run_o  (conv_run),
    .done_o (conv_done)
  );

  serial_shifter #(.W(WORD_W), .SCK_DIV(SCK_DIV)) shifter_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .launch_i  (launch),
    .word_i    (launch_word),
    .active_o  (sh_active),
    .done_o    (sh_done),
    .sdo_raw_o (sdo_raw),
    .sck_raw_o (sck_raw)
  );

  assign out_en = !ext_clk_sel_i && !cs_n_i && !rd_n_i;
  assign busy_o = busy_q;
  assign sck_o  = (out_en && sck_raw) ^ inv_sck_i;
  assign sync_o = (out_en && sh_active) ^ inv_sync_i;
  assign sdo_o  = out_en && sdo_raw;

  // R2: busy rises only after an accepted start strobe
  a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(busy_q) |-> $past(start_i));

  // R3: a read-after transfer keeps busy asserted
  a_r3_busy_covers_shift: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sh_active && ord_q == ORD_AFTER) |-> busy_q);

  // R4: in read-during order, busy drops exactly at conversion end
  a_r4_fall_at_conv_end: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($fell(busy_q) && ord_q == ORD_DURING) |-> $past(conv_done));

  // R4: a new transfer never starts on top of a running one
  a_r4_launch_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    launch |-> !sh_active);

  // R10: with the external clock selected, no transfer runs
  a_r10_no_master_shift: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_q && ext_q) |-> !sh_active);

  // R2: a conversion only runs under busy
  a_r2_conv_under_busy: assert property (@(posedge clk) disable iff (!rst_int_n)
    conv_run |-> busy_q);
endmodule

// File: tb/conv_serial_master_tb_top.sv
module conv_serial_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CONV       = 32;
  localparam int DIV        = 2;
  localparam int SHIFT      = 16 * DIV;
  localparam int NMAX       = 80;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, ext_clk_sel_i, rd_mode_i, inv_sck_i, inv_sync_i;
  logic        cs_n_i, rd_n_i;
  logic [15:0] sample_i;
  logic        busy_o, sck_o, sync_o, sdo_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  conv_serial_master #(.CONV_CYCLES(CONV), .SCK_DIV(DIV)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .ext_clk_sel_i (ext_clk_sel_i),
    .rd_mode_i     (rd_mode_i),
    .inv_sck_i     (inv_sck_i),
    .inv_sync_i    (inv_sync_i),
    .cs_n_i        (cs_n_i),
    .rd_n_i        (rd_n_i),
    .sample_i      (sample_i),
    .busy_o        (busy_o),
    .sck_o         (sck_o),
    .sync_o        (sync_o),
    .sdo_o         (sdo_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0; start_i = 1'b0; ext_clk_sel_i = 1'b0; rd_mode_i = 1'b0;
    inv_sck_i = 1'b0; inv_sync_i = 1'b0; cs_n_i = 1'b0; rd_n_i = 1'b0;
    sample_i = 16'h0;
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", busy_o, 0);
    check("R1", "sdo in reset", sdo_o, 0);
    check("R1", "sck idle low", sck_o, 0);
    check("R1", "sync inactive", sync_o, 0);
    inv_sck_i = 1'b1; inv_sync_i = 1'b1;
    @(negedge clk);
    check("R1", "sck idle inverted", sck_o, 1);
    check("R1", "sync inactive inverted", sync_o, 1);
    inv_sck_i = 1'b0; inv_sync_i = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // one conversion; the start strobe is sampled on the first rising edge
  task automatic run_conv(input string req, input logic mode, input logic ext,
                          input logic csn, input logic rdn, input logic isck,
                          input logic isync, input logic [15:0] smp,
                          input logic [15:0] exp_word, input int exp_busy,
                          input int exp_first, input logic exp_act,
                          input logic restart);
    int busy_cnt = 0, last_busy = 0, sync_cnt = 0, first_sync = 0;
    int sck_cnt = 0, bits = 0, ones = 0, unstable = 0;
    logic [15:0] word = '0;
    logic prev_sck = 1'b0, prev_sdo = 1'b0;
    rd_mode_i = mode; ext_clk_sel_i = ext; cs_n_i = csn; rd_n_i = rdn;
    inv_sck_i = isck; inv_sync_i = isync; sample_i = smp;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int n = 1; n <= NMAX; n++) begin
      logic s_act, y_act;
      s_act = sck_o ^ isck;
      y_act = sync_o ^ isync;
      if (busy_o) begin busy_cnt++; last_busy = n; end
      if (y_act) begin
        sync_cnt++;
        if (first_sync == 0) first_sync = n;
      end
      if (s_act) begin
        sck_cnt++;
        if (sdo_o != prev_sdo) unstable++;
        if (!prev_sck && bits < 16) begin
          word = {word[14:0], sdo_o};
          bits++;
        end
      end
      if (sdo_o) ones++;
      prev_sck = s_act;
      prev_sdo = sdo_o;
      start_i = restart && (n == 10);
      @(negedge clk);
    end
    start_i = 1'b0;
    check(req, "busy length", busy_cnt, exp_busy);
    check(req, "busy last cycle", last_busy, exp_busy);
    if (exp_act) begin
      check(req, "received word", word, exp_word);
      check(req, "first strobe cycle", first_sync, exp_first);
      check("R6", "strobe length", sync_cnt, SHIFT);
      check("R5", "clock high cycles", sck_cnt, 16 * (DIV / 2));
      check("R5", "data changed on high clock", unstable, 0);
    end else begin
      check(req, "strobe stays inactive", sync_cnt, 0);
      check(req, "clock stays idle", sck_cnt, 0);
      check(req, "data held low", ones, 0);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic test_during_first();
    // R4: nothing converted yet, so the word read out is zero
    run_conv("R4", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1234, 16'h0000, CONV, 1, 1'b1, 1'b0);
  endtask

  task automatic test_during_next();
    // R4 and R2: previous result read while converting; a second start is ignored (R8)
    run_conv("R4", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'hBEEF, 16'h1234, CONV, 1, 1'b1, 1'b1);
    run_conv("R8", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h4321, 16'hBEEF, CONV, 1, 1'b1, 1'b0);
  endtask

  task automatic test_after();
    // R3: word just converted, busy held through the transfer
    run_conv("R3", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'hA5C3, 16'hA5C3, CONV + SHIFT, CONV + 1, 1'b1, 1'b0);
    // R2: the read-after conversion also stored its result
    run_conv("R2", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0F0F, 16'hA5C3, CONV, 1, 1'b1, 1'b0);
  endtask

  task automatic test_invert();
    // R7: inverted clock and strobe
    run_conv("R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h3C96, 16'h3C96, CONV + SHIFT, CONV + 1, 1'b1, 1'b0);
    @(negedge clk);
    check("R7", "inverted clock idles high", sck_o, 1);
    check("R7", "inverted strobe idles high", sync_o, 1);
  endtask

  task automatic test_restart();
    // R8: a start during a read-after run does not change its length
    run_conv("R8", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h8001, 16'h8001, CONV + SHIFT, CONV + 1, 1'b1, 1'b1);
    check("R8", "busy low after run", busy_o, 0);
  endtask

  task automatic test_gating();
    // R9: deselected or not reading: pins quiet, timing unchanged
    run_conv("R9", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h7777, 16'h0, CONV + SHIFT, 0, 1'b0, 1'b0);
    run_conv("R9", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h1111, 16'h0, CONV, 0, 1'b0, 1'b0);
  endtask

  task automatic test_ext();
    // R10: external clock select, no transfer, busy ends with conversion
    run_conv("R10", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h2222, 16'h0, CONV, 0, 1'b0, 1'b0);
    // R10: the result of that conversion was still stored
    run_conv("R10", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h2222, CONV, 1, 1'b1, 1'b0);
  endtask

  initial begin
    test_reset();
    test_during_first();
    test_during_next();
    test_after();
    test_invert();
    test_restart();
    test_gating();
    test_ext();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule